// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Check

This block keeps the in-flight loads of an out-of-order core in a circular queue, in program order. Each load gets a slot at the tail when it is dispatched. The slot records the load's sequence number and the store-queue tail position at that moment, or a "no older store" flag when the store queue is empty. When its effective address is known, the load writes the address into its slot. Loads leave from the head when the commit stage reports the youngest retired sequence number. They are cut from the tail when a branch or exception squashes everything younger than a given sequence number.

When a store executes, the block scans the loads that follow it in program order, from the load index the store recorded up to the load tail. A load whose address falls in the same 256-byte region as the store's address has read memory too early. The first such load is latched as the ordering violator. The violator stays latched until the consumer takes it. The block also holds a blocked-load marker that a squash older than the blocked load cancels, and it reports how many memory operations the combined load/store queue can still accept.

Top module: `lq_order_check`

## Requirements
- R1: The queue has CAP usable slots out of CAP+1 physical slots. `lq_full` is high when CAP loads are held, and an allocation request while full changes nothing.
- R2: An accepted allocation writes slot `alloc_idx`, which then advances by one. The slot records the sequence number and the store-queue tail, or sets the no-store flag when `alloc_sq_empty` is high. The slot starts with no valid address and with a stored address of zero.
- R3: An address update writes the address into the given slot and marks the address valid.
- R4: A store check examines the live slots from `st_lq_idx` up to the tail, excluding the tail, in ring order. It compares addr[ADDR_W-1:8] and ignores loads without a valid address and slots before the start index. On a hit, `viol_valid` and `viol_idx` show the first (oldest) hit from the next cycle on.
- R5: While `viol_valid` is high, store checks are skipped and the latched index holds. A check that finds no hit leaves `viol_valid` low.
- R6: `viol_take` while `viol_valid` is high clears `viol_valid` in the next cycle.
- R7: A commit removes from the head every live load whose sequence number is less than or equal to `commit_seq`.
- R8: A squash removes every live load whose sequence number is greater than `squash_seq`, and the tail moves back past them. In a squash cycle, allocation and commit are ignored.
- R9: `blk_set` latches `blk_pend` with `blk_seq`. A squash with `squash_seq` strictly below the latched number clears `blk_pend`. Any other squash leaves it set.
- R10: `free_slots` equals min(CAP − loads held, SQ_CAP − `sq_used`).
- R11: Slot indices wrap from CAP to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_tail | input | SQ_IW | Store-queue tail at allocation |
| alloc_sq_empty | input | 1 | Store queue holds no stores |
| alloc_idx | output | IW | Slot the next allocation takes |
| lq_full | output | 1 | CAP loads held |
| addr_we | input | 1 | Address update strobe |
| addr_idx | input | IW | Slot to update |
| addr_val | input | ADDR_W | Effective address |
| st_chk | input | 1 | Store executes, run the scan |
| st_addr | input | ADDR_W | Store address |
| st_lq_idx | input | IW | Load index the store recorded |
| commit_req | input | 1 | Retire loads |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_req | input | 1 | Squash younger loads |
| squash_seq | input | SEQ_W | Squash bound |
| blk_set | input | 1 | Record a blocked load |
| blk_seq | input | SEQ_W | Blocked load's sequence number |
| blk_pend | output | 1 | Blocked-load marker |
| sq_used | input | SQ_IW | Stores held in the store queue |
| free_slots | output | FW | Entries the combined queue can accept |
| viol_take | input | 1 | Consume the violator |
| viol_valid | output | 1 | Violation latched |
| viol_idx | output | IW | Slot of the violating load |
| rd_idx | input | IW | Slot lookup index |
| rd_live | output | 1 | Slot holds a load |
| rd_seq | output | SEQ_W | Slot sequence number |
| rd_sq_idx | output | SQ_IW | Slot's recorded store index |
| rd_sq_none | output | 1 | Slot recorded an empty store queue |
| rd_addr_ok | output | 1 | Slot address is valid |

## Verification
The hardest state to reach is a violation scan over a partially filled ring whose live range has wrapped past the top slot. That range must also mix loads with and without a valid address, and loads before and after the store's start index. The stimulus fills the queue, commits part of the head, and allocates across the wrap point. It then squashes back, writes addresses into chosen slots only, and issues checks with start indices on both sides of the matching loads. A second check is issued while a violation is still latched, which shows that the scan is skipped.

// File: rtl/lq_pkg.sv
package lq_pkg;
  function automatic int ring_add(int a, int b, int n);
    return (a + b) % n;
  endfunction

  function automatic int ring_dist(int from, int to, int n);
    return (to - from + n) % n;
  endfunction

  function automatic logic same_region(logic [63:0] a, logic [63:0] b, int shift);
    return (a >> shift) == (b >> shift);
  endfunction

  function automatic int min_int(int a, int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/lq_slots.sv
module lq_slots #(
  parameter int DEPTH  = 9,
  parameter int IW     = 4,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SQ_IW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic [SQ_IW-1:0]  wr_sq_idx,
  input  logic              wr_sq_none,
  input  logic              au_en,
  input  logic [IW-1:0]     au_idx,
  input  logic [ADDR_W-1:0] au_addr,
  input  logic [DEPTH-1:0]  kill_mask,
  output logic [DEPTH-1:0]  live,
  output logic [DEPTH-1:0]  addr_ok,
  output logic [DEPTH-1:0]  sq_none,
  output logic [SEQ_W-1:0]  seq   [DEPTH],
  output logic [ADDR_W-1:0] addr  [DEPTH],
  output logic [SQ_IW-1:0]  sq_idx[DEPTH]
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic hit_wr, hit_au;
    assign hit_wr = wr_en && (int'(wr_idx) == s);
    assign hit_au = au_en && (int'(au_idx) == s);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live[s]    <= 1'b0;
        addr_ok[s] <= 1'b0;
        sq_none[s] <= 1'b0;
        seq[s]     <= '0;
        addr[s]    <= '0;
        sq_idx[s]  <= '0;
      end else if (hit_wr) begin
        live[s]    <= 1'b1;
        addr_ok[s] <= 1'b0;
        sq_none[s] <= wr_sq_none;
        seq[s]     <= wr_seq;
        addr[s]    <= '0;
        sq_idx[s]  <= wr_sq_none ? '0 : wr_sq_idx;
      end else begin
        if (kill_mask[s]) live[s] <= 1'b0;
        if (hit_au) begin
          addr[s]    <= au_addr;
          addr_ok[s] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lq_trim.sv
module lq_trim #(
  parameter int DEPTH = 9,
  parameter int IW    = 4,
  parameter int SEQ_W = 16
) (
  input  logic [IW-1:0]    head,
  input  logic [IW-1:0]    used,
  input  logic [DEPTH-1:0] live,
  input  logic [SEQ_W-1:0] seq [DEPTH],
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic [DEPTH-1:0] old_mask,
  output logic [DEPTH-1:0] young_mask,
  output logic [IW-1:0]    old_cnt,
  output logic [IW-1:0]    young_cnt
);
  import lq_pkg::*;

  always_comb begin
    old_mask   = '0;
    young_mask = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = ring_add(int'(head), k, DEPTH);
      if (k < int'(used) && live[idx]) begin
        if (seq[idx] <= commit_seq) old_mask[idx]   = 1'b1;
        if (seq[idx] >  squash_seq) young_mask[idx] = 1'b1;
      end
    end
    old_cnt   = IW'($countones(old_mask));
    young_cnt = IW'($countones(young_mask));
  end
endmodule

// File: rtl/lq_scan.sv
module lq_scan #(
  parameter int DEPTH      = 9,
  parameter int IW         = 4,
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 8
) (
  input  logic [IW-1:0]     start,
  input  logic [IW-1:0]     tail,
  input  logic [DEPTH-1:0]  live,
  input  logic [DEPTH-1:0]  addr_ok,
  input  logic [ADDR_W-1:0] addr [DEPTH],
  input  logic [ADDR_W-1:0] st_addr,
  output logic              hit,
  output logic [IW-1:0]     hit_idx
);
  import lq_pkg::*;

  always_comb begin
    int span;
    span    = ring_dist(int'(start), int'(tail), DEPTH);
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      int idx;
      idx = ring_add(int'(start), k, DEPTH);
      if (k < span && live[idx] && addr_ok[idx] &&
          same_region(64'(addr[idx]), 64'(st_addr), PAGE_SHIFT)) begin
        hit     = 1'b1;
        hit_idx = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/lq_order_check.sv
module lq_order_check #(
  parameter int CAP        = 8,
  parameter int SQ_CAP     = 8,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 8,
  localparam int DEPTH     = CAP + 1,
  localparam int IW        = $clog2(DEPTH),
  localparam int SQ_IW     = $clog2(SQ_CAP + 1),
  localparam int FW        = $clog2(((CAP > SQ_CAP) ? CAP : SQ_CAP) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [SQ_IW-1:0]  alloc_sq_tail,
  input  logic              alloc_sq_empty,
  output logic [IW-1:0]     alloc_idx,
  output logic              lq_full,
  input  logic              addr_we,
  input  logic [IW-1:0]     addr_idx,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              st_chk,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [IW-1:0]     st_lq_idx,
  input  logic              commit_req,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_req,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              blk_set,
  input  logic [SEQ_W-1:0]  blk_seq,
  output logic              blk_pend,
  input  logic [SQ_IW-1:0]  sq_used,
  output logic [FW-1:0]     free_slots,
  input  logic              viol_take,
  output logic              viol_valid,
  output logic [IW-1:0]     viol_idx,
  input  logic [IW-1:0]     rd_idx,
  output logic              rd_live,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [SQ_IW-1:0]  rd_sq_idx,
  output logic              rd_sq_none,
  output logic              rd_addr_ok
);
  import lq_pkg::*;

  logic [IW-1:0]     head, tail, used;
  logic [SEQ_W-1:0]  blk_seq_q;
  logic [DEPTH-1:0]  live, addr_ok, sq_none, old_mask, young_mask, kill_mask;
  logic [SEQ_W-1:0]  seq    [DEPTH];
  logic [ADDR_W-1:0] addr   [DEPTH];
  logic [SQ_IW-1:0]  sq_idx [DEPTH];
  logic [IW-1:0]     old_cnt, young_cnt, hit_idx;
  logic              hit;

  // Named internal events
  logic alloc_fire, commit_fire, squash_fire, scan_fire, blk_cancel;

  assign used        = IW'(ring_dist(int'(head), int'(tail), DEPTH));
  assign lq_full     = (ring_add(int'(tail), 1, DEPTH) == int'(head));
  assign alloc_idx   = tail;
  assign squash_fire = squash_req;
  assign alloc_fire  = alloc_req && !squash_req && !lq_full;
  assign commit_fire = commit_req && !squash_req;
  assign scan_fire   = st_chk && !viol_valid;
  assign blk_cancel  = squash_req && blk_pend && (squash_seq < blk_seq_q);
  assign kill_mask   = squash_fire ? young_mask : (commit_fire ? old_mask : '0);

  assign free_slots = FW'(min_int(CAP - int'(used), SQ_CAP - int'(sq_used)));

  lq_slots #(.DEPTH(DEPTH), .IW(IW), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SQ_IW(SQ_IW)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_fire), .wr_idx(tail), .wr_seq(alloc_seq),
    .wr_sq_idx(alloc_sq_tail), .wr_sq_none(alloc_sq_empty),
    .au_en(addr_we), .au_idx(addr_idx), .au_addr(addr_val),
    .kill_mask(kill_mask),
    .live(live), .addr_ok(addr_ok), .sq_none(sq_none),
    .seq(seq), .addr(addr), .sq_idx(sq_idx)
  );

  lq_trim #(.DEPTH(DEPTH), .IW(IW), .SEQ_W(SEQ_W)) u_trim (
    .head(head), .used(used), .live(live), .seq(seq),
    .commit_seq(commit_seq), .squash_seq(squash_seq),
    .old_mask(old_mask), .young_mask(young_mask),
    .old_cnt(old_cnt), .young_cnt(young_cnt)
  );

  lq_scan #(.DEPTH(DEPTH), .IW(IW), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_scan (
    .start(st_lq_idx), .tail(tail), .live(live), .addr_ok(addr_ok),
    .addr(addr), .st_addr(st_addr), .hit(hit), .hit_idx(hit_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (commit_fire) head <= IW'(ring_add(int'(head), int'(old_cnt), DEPTH));
      if (squash_fire)
        tail <= IW'(ring_dist(int'(young_cnt), int'(tail), DEPTH));
      else if (alloc_fire)
        tail <= IW'(ring_add(int'(tail), 1, DEPTH));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_idx   <= '0;
    end else if (scan_fire) begin
      viol_valid <= hit;
      if (hit) viol_idx <= hit_idx;
    end else if (viol_take) begin
      viol_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_pend  <= 1'b0;
      blk_seq_q <= '0;
    end else if (blk_cancel) begin
      blk_pend  <= 1'b0;
      blk_seq_q <= '0;
    end else if (blk_set) begin
      blk_pend  <= 1'b1;
      blk_seq_q <= blk_seq;
    end
  end

  assign rd_live    = live[rd_idx];
  assign rd_seq     = seq[rd_idx];
  assign rd_sq_idx  = sq_idx[rd_idx];
  assign rd_sq_none = sq_none[rd_idx];
  assign rd_addr_ok = addr_ok[rd_idx];
endmodule

// File: rtl/lq_order_check_sva.sv
module lq_order_check_sva #(
  parameter int CAP   = 8,
  parameter int IW    = 4,
  parameter int SEQ_W = 16,
  parameter int FW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic             squash_req,
  input logic             lq_full,
  input logic [IW-1:0]    alloc_idx,
  input logic [IW-1:0]    used,
  input logic             viol_valid,
  input logic [IW-1:0]    viol_idx,
  input logic             viol_take,
  input logic             blk_pend,
  input logic [SEQ_W-1:0] blk_seq_q,
  input logic [SEQ_W-1:0] squash_seq,
  input logic [FW-1:0]    free_slots
);
  a_r1_full_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    lq_full && alloc_req && !squash_req |=> alloc_idx == $past(alloc_idx));

  a_r1_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used) <= CAP);

  a_r2_alloc_step: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !lq_full && !squash_req |=>
      int'(alloc_idx) == (int'($past(alloc_idx)) + 1) % (CAP + 1));

  a_r5_viol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid && !viol_take |=> viol_valid && viol_idx == $past(viol_idx));

  a_r6_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid && viol_take |=> !viol_valid);

  a_r8_squash_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    squash_req |=> used <= $past(used));

  a_r9_blk_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    squash_req && blk_pend && squash_seq < blk_seq_q |=> !blk_pend);

  a_r10_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_slots) <= CAP);
endmodule

bind lq_order_check lq_order_check_sva #(
  .CAP(CAP), .IW(IW), .SEQ_W(SEQ_W), .FW(FW)
) u_sva (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .squash_req(squash_req),
  .lq_full(lq_full), .alloc_idx(alloc_idx), .used(used),
  .viol_valid(viol_valid), .viol_idx(viol_idx), .viol_take(viol_take),
  .blk_pend(blk_pend), .blk_seq_q(blk_seq_q), .squash_seq(squash_seq),
  .free_slots(free_slots)
);

// File: tb/lq_order_check_tb.sv
module lq_order_check_tb;
  localparam int CAP = 8, SQ_CAP = 8, SEQ_W = 16, ADDR_W = 32;
  localparam int IW = 4, SQ_IW = 4, FW = 4;

  logic clk = 0, rst_n = 0;
  logic alloc_req = 0, alloc_sq_empty = 0, addr_we = 0, st_chk = 0;
  logic commit_req = 0, squash_req = 0, blk_set = 0, viol_take = 0;
  logic [SEQ_W-1:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0, blk_seq = 0;
  logic [SQ_IW-1:0] alloc_sq_tail = 0, sq_used = 0;
  logic [IW-1:0] addr_idx = 0, st_lq_idx = 0, rd_idx = 0;
  logic [ADDR_W-1:0] addr_val = 0, st_addr = 0;
  logic [IW-1:0] alloc_idx, viol_idx;
  logic lq_full, blk_pend, viol_valid, rd_live, rd_sq_none, rd_addr_ok;
  logic [FW-1:0] free_slots;
  logic [SEQ_W-1:0] rd_seq;
  logic [SQ_IW-1:0] rd_sq_idx;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lq_order_check #(.CAP(CAP), .SQ_CAP(SQ_CAP), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    alloc_req = 0; addr_we = 0; st_chk = 0; commit_req = 0;
    squash_req = 0; blk_set = 0; viol_take = 0;
  endtask

  task automatic alloc(int s, bit empty, int sqt);
    alloc_req = 1; alloc_seq = SEQ_W'(s); alloc_sq_empty = empty;
    alloc_sq_tail = SQ_IW'(sqt); step();
  endtask

  task automatic set_addr(int idx, logic [ADDR_W-1:0] a);
    addr_we = 1; addr_idx = IW'(idx); addr_val = a; step();
  endtask

  task automatic store_chk(int start, logic [ADDR_W-1:0] a);
    st_chk = 1; st_lq_idx = IW'(start); st_addr = a; step();
  endtask

  task automatic peek(int idx);
    rd_idx = IW'(idx); #1;
  endtask

  task automatic t_reset();
    chk("R1 reset alloc_idx", int'(alloc_idx), 0);
    chk("R1 reset full", int'(lq_full), 0);
    chk("R10 reset free", int'(free_slots), 8);
    chk("R4 reset viol", int'(viol_valid), 0);
    chk("R9 reset blk", int'(blk_pend), 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) alloc(10 + i, i == 0, 3);
    chk("R1 full", int'(lq_full), 1);
    chk("R1 alloc_idx at cap", int'(alloc_idx), 8);
    chk("R10 free full", int'(free_slots), 0);
    alloc(99, 0, 1);
    chk("R1 alloc ignored when full", int'(alloc_idx), 8);
    peek(8); chk("R1 slot8 empty", int'(rd_live), 0);
    peek(0); chk("R2 sq none", int'(rd_sq_none), 1);
    peek(1); chk("R2 sq idx", int'(rd_sq_idx), 3);
    chk("R2 sq none clear", int'(rd_sq_none), 0);
    chk("R2 addr not ok", int'(rd_addr_ok), 0);
    chk("R2 seq", int'(rd_seq), 11);
  endtask

  task automatic t_commit();
    commit_req = 1; commit_seq = 12; step();
    chk("R7 free after commit", int'(free_slots), 3);
    chk("R7 not full", int'(lq_full), 0);
    peek(2); chk("R7 slot2 retired", int'(rd_live), 0);
    peek(3); chk("R7 slot3 kept", int'(rd_live), 1);
  endtask

  task automatic t_wrap();
    alloc(18, 0, 4); alloc(19, 0, 4); alloc(20, 0, 4);
    chk("R11 wrapped alloc_idx", int'(alloc_idx), 2);
    chk("R11 full after wrap", int'(lq_full), 1);
    peek(0); chk("R11 slot0 seq", int'(rd_seq), 19);
  endtask

  task automatic t_squash();
    squash_req = 1; squash_seq = 15; alloc_req = 1; alloc_seq = 50;
    commit_req = 1; commit_seq = 13; step();
    chk("R8 tail back", int'(alloc_idx), 6);
    chk("R8 free after squash", int'(free_slots), 5);
    peek(3); chk("R8 commit ignored in squash", int'(rd_live), 1);
    peek(8); chk("R8 slot8 removed", int'(rd_live), 0);
  endtask

  task automatic t_scan();
    set_addr(3, 32'h1234_5600);
    peek(3); chk("R3 addr ok", int'(rd_addr_ok), 1);
    set_addr(4, 32'h0000_7700);
    store_chk(4, 32'h1234_56FF);
    chk("R4 slot before start ignored", int'(viol_valid), 0);
    store_chk(5, 32'h0000_0000);
    chk("R4 unaddressed never match", int'(viol_valid), 0);
    store_chk(3, 32'h1234_56AB);
    chk("R4 hit valid", int'(viol_valid), 1);
    chk("R4 hit idx", int'(viol_idx), 3);
    store_chk(4, 32'h0000_7710);
    chk("R5 held valid", int'(viol_valid), 1);
    chk("R5 held idx", int'(viol_idx), 3);
    viol_take = 1; step();
    chk("R6 take clears", int'(viol_valid), 0);
    set_addr(5, 32'h0000_7780);
    store_chk(3, 32'h0000_77FF);
    chk("R4 first of two", int'(viol_idx), 4);
    chk("R4 second hit valid", int'(viol_valid), 1);
    viol_take = 1; step();
    store_chk(3, 32'h0000_8000);
    chk("R5 no hit stays clear", int'(viol_valid), 0);
  endtask

  task automatic t_blocked();
    blk_set = 1; blk_seq = 14; step();
    chk("R9 set", int'(blk_pend), 1);
    squash_req = 1; squash_seq = 14; step();
    chk("R9 equal keeps", int'(blk_pend), 1);
    chk("R8 squash 14", int'(alloc_idx), 5);
    squash_req = 1; squash_seq = 13; step();
    chk("R9 older cancels", int'(blk_pend), 0);
    chk("R8 squash 13", int'(alloc_idx), 4);
  endtask

  task automatic t_free();
    sq_used = 6; #1;
    chk("R10 store side limits", int'(free_slots), 2);
    sq_used = 0; #1;
    chk("R10 load side limits", int'(free_slots), 7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_fill();
    t_commit();
    t_wrap();
    t_squash();
    t_scan();
    t_blocked();
    t_free();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule